// File: doc/BRIEF.md
# Filtered Branch Trace Recorder

This block sits beside a processor's retirement stage and records control transfers into a circular trace region in memory. Each retired control transfer arrives on an event port with its class, the privilege level it ran at, and its source and target addresses. Two filters pick what is kept. A per-class mask selects among eight transfer classes. A privilege qualifier selects user mode, kernel mode or both. Each kept event becomes one record, written through a record-write master port to a slot in a software-assigned region.

Software sets the region's base byte address, its depth in records, and a threshold of free slots. When the region gets close to full, an interrupt is raised so that a handler can drain the records in one batch. The handler then pulses a drain acknowledge, which sends the write index back to the first slot. Once the region is full, new kept events are thrown away and a sticky overflow flag is set. Records already written are never overwritten.

Top module: `brtrace_rec`

## Requirements
- R1: Record format. A record is written as `wrData = {target, source}`, with the target address in the upper half. The record goes to `wrAddr = cfgBase + index * (2*AW/8)`, where index is the number of records stored since reset or the last drain. `wrAddr` shows this slot address on every cycle, including cycles with no write.
- R2: Class filter. The class code is one of eight values: 0 conditional jump, 1 direct jump, 2 direct call, 3 indirect call, 4 indirect jump, 5 return, 6 interrupt, 7 exception. An event is kept only when bit `evKind` of `kindMask` is 1. A dropped event is accepted (`evReady` = 1) without a write, and the index does not change.
- R3: Privilege filter. When `evUser` = 1 the event is kept only if `privSel[0]` = 1. When `evUser` = 0 it is kept only if `privSel[1]` = 1. A rejected event is accepted without a write, and the index does not change.
- R4: `wrValid` is high only when `evValid` is high, the event passes both filters, the region is not full and no drain is pending. Each write handshake (`wrValid` and `wrReady` both high) stores exactly one record and adds one to the index.
- R5: Back-pressure. For an event that is kept while space remains, `evReady` equals `wrReady`.
- R6: The interrupt is raised by a record write that leaves `index + cfgThresh >= cfgDepth`. `irq` is registered, so it rises on the edge that stores that record. It then stays high until a drain acknowledge.
- R7: Full region. When `index >= cfgDepth`, a kept event is still accepted, but no write takes place. `overflow` is set on the next edge and stays set until a drain acknowledge. Events that fail a filter never set `overflow`.
- R8: While `drainAck` is high, `evReady` and `wrValid` are both 0. On the next edge the index returns to 0, and `irq` and `overflow` clear.
- R9: After reset, the index is 0 and `irq` and `overflow` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evValid | input | 1 | A retired control transfer is offered |
| evReady | output | 1 | The offered event is taken on this edge |
| evKind | input | 3 | Transfer class code (see R2) |
| evUser | input | 1 | 1 when the transfer ran in user mode, 0 when it ran in kernel mode |
| evSrc | input | AW | Branch source address |
| evDst | input | AW | Branch target address |
| cfgBase | input | AW | Byte address of slot 0 of the trace region |
| cfgDepth | input | IDXW | Region size in records |
| cfgThresh | input | IDXW | Free-slot margin that raises the interrupt |
| kindMask | input | 8 | One capture-enable bit per class code |
| privSel | input | 2 | Bit 0 enables user-mode capture, bit 1 enables kernel-mode capture |
| drainAck | input | 1 | Software has drained the region; the index restarts at 0 |
| wrValid | output | 1 | A record write is requested |
| wrReady | input | 1 | Memory side accepts the write |
| wrAddr | output | AW | Byte address of the current slot |
| wrData | output | 2*AW | Record: target in the upper half, source in the lower half |
| irq | output | 1 | Near-full interrupt, sticky |
| overflow | output | 1 | A kept event was dropped because the region was full, sticky |

## Verification
The bench builds the recorder with AW = 16 and IDXW = 4, which gives four-byte records and a region of only a handful of slots. It programs a depth of 6 with a threshold of 2, so the interrupt point, the full point and the drop-with-overflow case all come within about a dozen events. A second setting uses a depth of 2 with a threshold of 0, where the interrupt and the full point fall on the same record. The narrow address also makes the slot stride in `wrAddr` easy to predict, so it can be compared on every cycle.

// File: rtl/btr_pkg.sv
package btr_pkg;
  localparam int BR_KINDS = 8;
  localparam int BR_KW = $clog2(BR_KINDS);

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic push;   // a record write handshake completes this cycle
    logic drop;   // a kept event is discarded because the region is full
    logic clear;  // drain acknowledge: restart the index, clear the flags
  } btrStrobeT;
endpackage

// File: rtl/btr_ctrl.sv
module btr_ctrl
  import btr_pkg::*;
(
  input  logic                evValid,
  input  logic [BR_KW-1:0]    evKind,
  input  logic                evUser,
  input  logic [BR_KINDS-1:0] kindMask,
  input  logic [1:0]          privSel,
  input  logic                bufFull,
  input  logic                wrReady,
  input  logic                drainAck,
  output logic                evReady,
  output logic                wrValid,
  output btrStrobeT           strb
);
  logic kindOk;
  logic privOk;
  logic keep;
  logic room;

  always_comb begin
    kindOk  = kindMask[evKind];
    privOk  = evUser ? privSel[0] : privSel[1];
    keep    = kindOk && privOk;
    room    = keep && !bufFull;
    // A drain acknowledge takes the whole cycle; events wait behind it.
    wrValid = !drainAck && evValid && room;
    evReady = !drainAck && (!room || wrReady);
    strb.push  = wrValid && wrReady;
    strb.drop  = !drainAck && evValid && keep && bufFull;
    strb.clear = drainAck;
  end
endmodule

// File: rtl/btr_dpath.sv
module btr_dpath
  import btr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  btrStrobeT       strb,
  input  logic [AW-1:0]   cfgBase,
  input  logic [IDXW-1:0] cfgDepth,
  input  logic [IDXW-1:0] cfgThresh,
  input  logic [AW-1:0]   evSrc,
  input  logic [AW-1:0]   evDst,
  output logic [AW-1:0]   wrAddr,
  output logic [2*AW-1:0] wrData,
  output logic            bufFull,
  output logic            irq,
  output logic            overflow
);
  localparam int RECB = (2 * AW) / 8;
  localparam int RSH  = $clog2(RECB);
  localparam int CW   = IDXW + 2;

  logic [IDXW-1:0] wrIdx;
  logic [CW-1:0]   nextCnt;
  logic            nearFull;

  always_comb begin
    bufFull  = wrIdx >= cfgDepth;
    nextCnt  = CW'(wrIdx) + CW'(1);
    nearFull = (nextCnt + CW'(cfgThresh)) >= CW'(cfgDepth);
    wrAddr   = cfgBase + (AW'(wrIdx) << RSH);
    wrData   = {evDst, evSrc};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx    <= '0;
      irq      <= 1'b0;
      overflow <= 1'b0;
    end else if (strb.clear) begin
      wrIdx    <= '0;
      irq      <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (strb.push) begin
        wrIdx <= wrIdx + 1'b1;
        if (nearFull) irq <= 1'b1;
      end
      if (strb.drop) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/brtrace_rec.sv
module brtrace_rec
  import btr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                evValid,
  output logic                evReady,
  input  logic [2:0]          evKind,
  input  logic                evUser,
  input  logic [AW-1:0]       evSrc,
  input  logic [AW-1:0]       evDst,
  input  logic [AW-1:0]       cfgBase,
  input  logic [IDXW-1:0]     cfgDepth,
  input  logic [IDXW-1:0]     cfgThresh,
  input  logic [7:0]          kindMask,
  input  logic [1:0]          privSel,
  input  logic                drainAck,
  output logic                wrValid,
  input  logic                wrReady,
  output logic [AW-1:0]       wrAddr,
  output logic [2*AW-1:0]     wrData,
  output logic                irq,
  output logic                overflow
);
  btrStrobeT strb;
  logic      bufFull;

  btr_ctrl uCtrl (
    .evValid (evValid),
    .evKind  (evKind),
    .evUser  (evUser),
    .kindMask(kindMask),
    .privSel (privSel),
    .bufFull (bufFull),
    .wrReady (wrReady),
    .drainAck(drainAck),
    .evReady (evReady),
    .wrValid (wrValid),
    .strb    (strb)
  );

  btr_dpath #(.AW(AW), .IDXW(IDXW)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgBase  (cfgBase),
    .cfgDepth (cfgDepth),
    .cfgThresh(cfgThresh),
    .evSrc    (evSrc),
    .evDst    (evDst),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .bufFull  (bufFull),
    .irq      (irq),
    .overflow (overflow)
  );
endmodule

// File: rtl/brtrace_rec_chk.sv
module brtrace_rec_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          evValid,
  input logic          evReady,
  input logic          drainAck,
  input logic          wrValid,
  input logic          wrReady,
  input logic [AW-1:0] wrAddr,
  input logic          irq,
  input logic          overflow
);
  localparam int RECB = (2 * AW) / 8;

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(wrValid && wrReady) && !$past(drainAck) && wrValid)
      |-> (wrAddr == $past(wrAddr) + AW'(RECB)));

  assert_write_needs_event_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> evValid);

  assert_ready_follows_mem_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (evReady == wrReady));

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !drainAck) |=> irq);

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !drainAck) |=> overflow);

  assert_drain_stalls_R8: assert property (@(posedge clk) disable iff (!rstN)
    drainAck |-> (!wrValid && !evReady));

  assert_drain_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    drainAck |=> (!irq && !overflow));
endmodule

bind brtrace_rec brtrace_rec_chk #(.AW(AW)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .evValid (evValid),
  .evReady (evReady),
  .drainAck(drainAck),
  .wrValid (wrValid),
  .wrReady (wrReady),
  .wrAddr  (wrAddr),
  .irq     (irq),
  .overflow(overflow)
);

// File: tb/brtrace_rec_test.sv
module brtrace_rec_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IDXW = 4;
  localparam int RECB = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evValid = 1'b0;
  logic evReady;
  logic [2:0] evKind = '0;
  logic evUser = 1'b0;
  logic [AW-1:0] evSrc = '0;
  logic [AW-1:0] evDst = '0;
  logic [AW-1:0] cfgBase = 16'h4000;
  logic [IDXW-1:0] cfgDepth = 4'd6;
  logic [IDXW-1:0] cfgThresh = 4'd2;
  logic [7:0] kindMask = 8'hFF;
  logic [1:0] privSel = 2'b11;
  logic drainAck = 1'b0;
  logic wrValid;
  logic wrReady = 1'b0;
  logic [AW-1:0] wrAddr;
  logic [2*AW-1:0] wrData;
  logic irq;
  logic overflow;

  int nChecks = 0;
  int nErrors = 0;
  int mIdx = 0;
  bit mIrq = 1'b0;
  bit mOvf = 1'b0;
  int seq = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  brtrace_rec #(.AW(AW), .IDXW(IDXW)) uut (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evReady(evReady),
    .evKind(evKind), .evUser(evUser), .evSrc(evSrc), .evDst(evDst),
    .cfgBase(cfgBase), .cfgDepth(cfgDepth), .cfgThresh(cfgThresh),
    .kindMask(kindMask), .privSel(privSel), .drainAck(drainAck),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .irq(irq), .overflow(overflow)
  );

  function automatic bit mKeep();
    bit k = kindMask[evKind];
    bit p = evUser ? privSel[0] : privSel[1];
    return k && p;
  endfunction

  function automatic bit mFull();
    return mIdx >= int'(cfgDepth);
  endfunction

  function automatic bit mWrValid();
    return !drainAck && evValid && mKeep() && !mFull();
  endfunction

  function automatic bit mReady();
    return !drainAck && (!(mKeep() && !mFull()) || wrReady);
  endfunction

  // Reference model, advanced on each edge from the inputs held since the last falling edge
  always @(posedge clk) begin
    if (!rstN) begin
      mIdx = 0; mIrq = 1'b0; mOvf = 1'b0;
    end else if (drainAck) begin
      mIdx = 0; mIrq = 1'b0; mOvf = 1'b0;
    end else if (evValid && mReady()) begin
      if (mKeep() && !mFull()) begin
        if (mIdx + 1 + int'(cfgThresh) >= int'(cfgDepth)) mIrq = 1'b1;
        mIdx = mIdx + 1;
      end else if (mKeep() && mFull()) begin
        mOvf = 1'b1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input int k, input bit u, input bit rdy,
                      input bit dr, input string tag);
    @(negedge clk);
    seq++;
    evValid = v; evKind = 3'(k); evUser = u; wrReady = rdy; drainAck = dr;
    evSrc = 16'h1000 + 16'(seq);
    evDst = 16'h8000 ^ 16'(seq * 37);
    #1;
    check({tag, " R5 evReady"}, 32'(evReady), 32'(mReady()));
    check({tag, " R4 wrValid"}, 32'(wrValid), 32'(mWrValid()));
    check({tag, " R1 wrAddr"}, 32'(wrAddr), 32'(16'(int'(cfgBase) + mIdx * RECB)));
    if (mWrValid()) check({tag, " R1 wrData"}, wrData, {evDst, evSrc});
    check({tag, " R6 irq"}, 32'(irq), 32'(mIrq));
    check({tag, " R7 overflow"}, 32'(overflow), 32'(mOvf));
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R9: reset state
    step(0, 0, 0, 0, 0, "R9");
    step(1, 2, 1, 1, 0, "R9");
    @(negedge clk); rstN = 1'b1;
    step(0, 0, 0, 0, 0, "R9");

    // R1/R4: records of several classes, both privilege levels
    step(1, 2, 1, 1, 0, "R1");
    step(1, 3, 0, 1, 0, "R1");
    // R5: memory stalls hold the event
    step(1, 4, 1, 0, 0, "R5");
    step(1, 4, 1, 0, 0, "R5");
    step(1, 4, 1, 1, 0, "R5");

    // R2: class mask without conditional jumps and returns
    kindMask = 8'hDE;
    step(1, 0, 1, 0, 0, "R2");
    step(1, 5, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, "R2");
    step(1, 6, 0, 1, 0, "R6");   // index 4: 4+2 >= 6 raises irq
    step(0, 0, 0, 0, 0, "R6");

    // R3: privilege qualification
    kindMask = 8'hFF;
    privSel = 2'b01;
    step(1, 6, 0, 0, 0, "R3");   // kernel event rejected
    step(1, 7, 1, 1, 0, "R3");   // user event kept, index 5
    privSel = 2'b10;
    step(1, 1, 1, 0, 0, "R3");   // user event rejected
    step(0, 0, 0, 0, 0, "R3");
    privSel = 2'b11;
    step(1, 1, 0, 1, 0, "R4");   // index 6: full

    // R7: full region
    kindMask = 8'hFE;
    step(1, 0, 0, 0, 0, "R7");   // filtered while full: no overflow
    step(0, 0, 0, 0, 0, "R7");
    step(1, 1, 0, 0, 0, "R7");   // kept while full: dropped, overflow set
    step(1, 3, 1, 1, 0, "R7");
    step(0, 0, 0, 0, 0, "R7");

    // R8: drain acknowledge stalls and clears
    kindMask = 8'hFF;
    step(1, 2, 1, 1, 1, "R8");
    step(0, 0, 0, 0, 0, "R8");
    step(1, 2, 1, 1, 0, "R8");
    step(1, 5, 0, 1, 0, "R8");

    // Small region with zero margin: irq and full arrive together
    step(0, 0, 0, 0, 1, "R8");
    cfgDepth = 4'd2; cfgThresh = 4'd0;
    step(1, 2, 1, 1, 0, "R6");
    step(1, 3, 1, 1, 0, "R6");
    step(1, 4, 1, 1, 0, "R7");
    step(0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 0, "R8");

    finishRun();
  end
endmodule